// File: doc/BRIEF.md
# Serial Console Pin and Rate Finder

This block hunts for an asynchronous serial console on a bank of unknown pins. After a start pulse it visits every ordered pair of distinct channels, driving one of them as the transmit line and listening on the other. For each pair it steps through a fixed list of 24 bit rates. At each rate it sends a stored probe string of up to 16 bytes and then listens for a reply. A step that collects at least one well-formed byte is reported as a record holding the channel pair, the rate index and up to 16 received bytes.

Records leave on a valid/ready port, and the sweep waits while a record is pending. Bit timing comes from a divisor per rate, fixed when the design is elaborated from the clock frequency parameter. The reply window is measured in silent clock cycles and is rearmed after each byte, so a longer reply gets a longer window.

Top module: `uart_sweep`

## Requirements
- R1: After reset `busy` and `res_valid` are low and every bit of `pin_oe` is low.
- R2: Each transmitted frame is a low start bit, 8 data bits with the least significant bit first, and a high stop bit. There is no parity bit, and the line rests high between frames. Each bit lasts CLK_HZ/rate clock cycles, with a floor of 1 cycle.
- R3: Rate index k (0 to 23) selects, in this order: 75, 110, 150, 300, 900, 1200, 1800, 2400, 3600, 4800, 7200, 9600, 14400, 19200, 28800, 31250, 38400, 57600, 76800, 115200, 153600, 230400, 250000 and 307200 bit/s. Index 11 is 9600. Each pair is tried at all 24 rates in ascending index order before the sweep moves on to the next pair.
- R4: Pairs are ordered with the transmit channel outermost and the receive channel inner, both ascending, skipping equal channels, for N·(N−1) pairs. A start with a channel count below 2 runs no sweep. A count above NCH is treated as NCH.
- R5: While busy, exactly one `pin_oe` bit is high: the transmit channel's. The receive channel and all other channels are never enabled. When idle, every `pin_oe` bit is low.
- R6: At every step the whole probe is sent, bytes in index order with byte i taken from `probe_data[8i+7:8i]`. Lengths above 16 count as 16.
- R7: After the probe has been sent, listening ends once CLK_HZ/50 consecutive cycles pass with the receiver idle. The count restarts after every byte that is kept.
- R8: At most 16 bytes are kept per step, and the step ends as soon as the 16th arrives. Byte j goes to `res_data[8j+7:8j]`.
- R9: The receiver confirms a start bit at mid-bit and samples each bit at its centre. A frame whose stop bit is low is dropped.
- R10: A record is offered only when the step kept one or more bytes. It carries the transmit channel, the receive channel, the rate index, the byte count and the bytes.
- R11: While `res_valid` is high and `res_ready` is low, the record and the pin drive stay unchanged. The sweep resumes only after the record is accepted.
- R12: `busy` falls after the last rate of the last pair has finished.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a sweep when idle |
| chan_count | input | $clog2(NCH+1) | Number of channels to sweep |
| probe_len | input | 5 | Probe length in bytes |
| probe_data | input | 128 | Probe bytes, byte 0 lowest |
| pin_in | input | NCH | Sensed level of each channel |
| pin_out | output | NCH | Drive level toward the channels |
| pin_oe | output | NCH | Drive enable per channel |
| busy | output | 1 | Sweep in progress |
| res_valid | output | 1 | Record available |
| res_ready | input | 1 | Record accepted when high with valid |
| res_tx | output | $clog2(NCH) | Transmit channel of the record |
| res_rx | output | $clog2(NCH) | Receive channel of the record |
| res_baud | output | 5 | Rate index of the record |
| res_count | output | 5 | Number of bytes kept (1 to 16) |
| res_data | output | 128 | Bytes kept, byte 0 lowest |

## Verification
The reply window restart and the acceptance of a byte happen in the same cycle. The bench provokes this by placing the second reply byte just inside one window after the first byte, so the step lasts longer than a single window measured from its start. The check is that both bytes appear in the record and that a malformed frame sent before them is dropped. Receiving the 16th byte and the arrival of further reply bytes also overlap. The bench sends 18 bytes back to back and checks for a count of exactly 16 with the first 16 values.

// File: rtl/uart_sweep.sv
module uart_sweep #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned NCH = 8,
  localparam int CW = $clog2(NCH),
  localparam int CNW = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNW-1:0]   chan_count,
  input  logic [4:0]       probe_len,
  input  logic [127:0]     probe_data,
  input  logic [NCH-1:0]   pin_in,
  output logic [NCH-1:0]   pin_out,
  output logic [NCH-1:0]   pin_oe,
  output logic             busy,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [CW-1:0]    res_tx,
  output logic [CW-1:0]    res_rx,
  output logic [4:0]       res_baud,
  output logic [4:0]       res_count,
  output logic [127:0]     res_data
);
  localparam int AW = CNW + 1;
  localparam int unsigned TMO = (CLK_HZ / 50 == 0) ? 1 : CLK_HZ / 50;
  localparam int unsigned RATES [24] = '{75, 110, 150, 300, 900, 1200, 1800, 2400,
    3600, 4800, 7200, 9600, 14400, 19200, 28800, 31250, 38400, 57600, 76800,
    115200, 153600, 230400, 250000, 307200};

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_LISTEN, S_REPORT} st_t;
  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rs_t;

  logic [31:0] divtab [24];
  for (genvar g = 0; g < 24; g++) begin : g_div
    localparam int unsigned Q = CLK_HZ / RATES[g];
    localparam int unsigned QF = (Q == 0) ? 1 : Q;
    assign divtab[g] = 32'(QF);
  end

  st_t          state;
  rs_t          rs;
  logic [CNW-1:0] n_r;
  logic [CW-1:0]  txc, rxc;
  logic [4:0]   bidx, plen, bsent, count;
  logic [127:0] pdat, data;
  logic [9:0]   tsh;
  logic [3:0]   tbit;
  logic [31:0]  tcnt, rcnt, tmo, div, half;
  logic [2:0]   rbit;
  logic [7:0]   rsh;
  logic         rprev, rline, tx_line, last_baud, wrap, sweep_end;
  logic [AW-1:0] rx_a, rx_b, tx_a;
  logic [CNW-1:0] nclamp;

  assign div       = divtab[bidx];
  assign half      = div >> 1;
  assign rline     = pin_in[rxc];
  assign tx_line   = (tbit != 0) ? tsh[0] : 1'b1;
  assign last_baud = (bidx == 5'd23);
  assign rx_a      = AW'(rxc) + AW'(1);
  assign rx_b      = (rx_a == AW'(txc)) ? rx_a + AW'(1) : rx_a;
  assign wrap      = rx_b >= AW'(n_r);
  assign tx_a      = AW'(txc) + AW'(1);
  assign sweep_end = last_baud && wrap && (tx_a >= AW'(n_r));
  assign nclamp    = (chan_count > CNW'(NCH)) ? CNW'(NCH) : chan_count;

  assign busy      = (state != S_IDLE);
  assign pin_oe    = busy ? ({{(NCH-1){1'b0}}, 1'b1} << txc) : '0;
  assign pin_out   = {NCH{tx_line}};
  assign res_valid = (state == S_REPORT) && (count != 0);
  assign res_tx    = txc;
  assign res_rx    = rxc;
  assign res_baud  = bidx;
  assign res_count = count;
  assign res_data  = data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; rs <= R_IDLE; n_r <= '0; txc <= '0; rxc <= '0;
      bidx <= '0; plen <= '0; bsent <= '0; count <= '0; pdat <= '0; data <= '0;
      tsh <= '1; tbit <= '0; tcnt <= '0; rcnt <= '0; tmo <= '0; rbit <= '0;
      rsh <= '0; rprev <= 1'b1;
    end else begin
      rprev <= rline;
      case (state)
        S_IDLE: if (start && nclamp >= CNW'(2)) begin
          n_r <= nclamp; txc <= '0; rxc <= CW'(1); bidx <= '0;
          pdat <= probe_data; plen <= (probe_len > 5'd16) ? 5'd16 : probe_len;
          bsent <= '0; tbit <= '0; state <= S_SEND;
        end
        S_SEND: begin
          if (tbit == 0) begin
            if (bsent == plen) begin
              state <= S_LISTEN; rs <= R_IDLE; rprev <= 1'b1;
              count <= '0; data <= '0; tmo <= '0;
            end else begin
              tsh <= {1'b1, pdat[{bsent[3:0], 3'b000} +: 8], 1'b0};
              tbit <= 4'd10; tcnt <= '0; bsent <= bsent + 5'd1;
            end
          end else if (tcnt == div - 1) begin
            tcnt <= '0; tsh <= {1'b1, tsh[9:1]}; tbit <= tbit - 4'd1;
          end else tcnt <= tcnt + 1;
        end
        S_LISTEN: begin
          if (count == 5'd16) state <= S_REPORT;
          else case (rs)
            R_IDLE: begin
              if (rprev && !rline) begin rs <= R_START; rcnt <= 32'd1; end
              else if (tmo == TMO - 1) state <= S_REPORT;
              else tmo <= tmo + 1;
            end
            R_START: begin
              if (rcnt >= half) begin
                if (!rline) begin rs <= R_DATA; rcnt <= '0; rbit <= '0; end
                else rs <= R_IDLE;
              end else rcnt <= rcnt + 1;
            end
            R_DATA: begin
              if (rcnt == div - 1) begin
                rcnt <= '0; rsh <= {rline, rsh[7:1]}; rbit <= rbit + 3'd1;
                if (rbit == 3'd7) rs <= R_STOP;
              end else rcnt <= rcnt + 1;
            end
            R_STOP: begin
              if (rcnt == div - 1) begin
                rcnt <= '0; rs <= R_IDLE;
                if (rline) begin
                  data[{count[3:0], 3'b000} +: 8] <= rsh;
                  count <= count + 5'd1; tmo <= '0;
                end
              end else rcnt <= rcnt + 1;
            end
          endcase
        end
        S_REPORT: if (count == 0 || res_ready) begin
          bidx <= last_baud ? 5'd0 : bidx + 5'd1;
          if (last_baud && wrap) begin txc <= CW'(tx_a); rxc <= '0; end
          else if (last_baud) rxc <= CW'(rx_b);
          bsent <= '0; tbit <= '0;
          state <= sweep_end ? S_IDLE : S_SEND;
        end
      endcase
    end
  end

  // R5
  rx_never_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(pin_oe) == 1 && !pin_oe[rxc]));
  // R5
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pin_oe == '0));
  // R11
  record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_count)
      && $stable(res_baud) && $stable(pin_oe)));
  // R10
  record_content_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_count != 0 && res_count <= 5'd16 && res_tx != res_rx));
  // R2
  line_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LISTEN) |-> (&pin_out));
endmodule

// File: tb/sim_uart_sweep.sv
module sim_uart_sweep;
  localparam int unsigned CLK_HZ = 32000;
  localparam int NCH = 4;
  localparam int DR = CLK_HZ / 9600;
  localparam int TMO = CLK_HZ / 50;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, res_ready = 1'b1;
  logic [2:0] chan_count = '0;
  logic [4:0] probe_len = '0;
  logic [127:0] probe_data = '0;
  logic [NCH-1:0] bank_in = '1;
  logic [NCH-1:0] pin_out, pin_oe;
  logic busy, res_valid;
  logic [1:0] res_tx, res_rx;
  logic [4:0] res_baud, res_count;
  logic [127:0] res_data;

  int checks = 0, fails = 0;
  int resp_mode = 0, resp_rx_ch = 0, resp_tx_ch = 1, resp_plen = 1;
  logic [7:0] exp_first = '0, exp_last = '0;
  logic seen = 1'b0;
  logic hear;

  int nrec = 0;
  int rec_tx [32], rec_rx [32], rec_baud [32], rec_cnt [32];
  logic [127:0] rec_data [32];
  int oe_n = 0, oe_bad = 0;
  logic [NCH-1:0] oe_log [8];
  logic [NCH-1:0] last_oe = '0;

  always #2 clk = ~clk;

  uart_sweep #(.CLK_HZ(CLK_HZ), .NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_count(chan_count),
    .probe_len(probe_len), .probe_data(probe_data), .pin_in(bank_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .busy(busy), .res_valid(res_valid),
    .res_ready(res_ready), .res_tx(res_tx), .res_rx(res_rx), .res_baud(res_baud),
    .res_count(res_count), .res_data(res_data));

  assign hear = pin_oe[resp_rx_ch] ? pin_out[resp_rx_ch] : 1'b1;

  task automatic check(input logic cond, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(negedge clk) begin
    if (res_valid && res_ready && nrec < 32) begin
      rec_tx[nrec] = res_tx; rec_rx[nrec] = res_rx; rec_baud[nrec] = res_baud;
      rec_cnt[nrec] = res_count; rec_data[nrec] = res_data; nrec++;
    end
    if (pin_oe != last_oe && pin_oe != '0 && oe_n < 8) begin
      oe_log[oe_n] = pin_oe; oe_n++;
    end
    last_oe = pin_oe;
    if (busy && $countones(pin_oe) != 1) oe_bad++;
  end

  task automatic send_byte(input int ch, input logic [7:0] b, input logic stop_ok);
    bank_in[ch] = 1'b0; repeat (DR) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      bank_in[ch] = b[i]; repeat (DR) @(negedge clk);
    end
    bank_in[ch] = stop_ok; repeat (DR) @(negedge clk);
    bank_in[ch] = 1'b1;
  endtask

  task automatic recv_byte(output logic [7:0] b, output logic ok);
    while (hear !== 1'b1) @(negedge clk);
    while (hear === 1'b1) @(negedge clk);
    repeat (DR / 2) @(negedge clk);
    ok = (hear == 1'b0);
    for (int i = 0; i < 8; i++) begin
      repeat (DR) @(negedge clk);
      b[i] = hear;
    end
    repeat (DR) @(negedge clk);
    ok = ok && (hear == 1'b1);
  endtask

  initial begin : responder
    logic [7:0] b, prev;
    logic ok;
    prev = '0;
    forever begin
      recv_byte(b, ok);
      if (ok && resp_mode != 0) begin
        if (b == exp_last && (resp_plen == 1 || prev == exp_first)) begin
          seen = 1'b1;
          repeat (2 * DR) @(negedge clk);
          if (resp_mode == 1) begin
            send_byte(resp_tx_ch, 8'h5A, 1'b0);
            repeat (2 * DR) @(negedge clk);
            send_byte(resp_tx_ch, 8'h3C, 1'b1);
            repeat (TMO - 20) @(negedge clk);
            send_byte(resp_tx_ch, 8'hC3, 1'b1);
          end else begin
            for (int k = 0; k < 18; k++) send_byte(resp_tx_ch, 8'(8'h10 + k), 1'b1);
          end
        end
        prev = b;
      end
    end
  end

  task automatic run_sweep(input int nch, input int len, input logic [127:0] pd);
    @(negedge clk);
    chan_count = 3'(nch); probe_len = 5'(len); probe_data = pd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy, "R1", "busy after reset", busy, 0);
    check(!res_valid, "R1", "valid after reset", res_valid, 0);
    check(pin_oe == '0, "R1", "oe after reset", pin_oe, 0);
  endtask

  task automatic t_one_channel;
    int n0 = nrec;
    run_sweep(1, 1, 128'h55);
    repeat (20) @(negedge clk);
    check(!busy && nrec == n0, "R4", "single channel starts no sweep", busy, 0);
  endtask

  task automatic t_console_a;
    logic [127:0] held;
    int hit = -1, wrong = 0;
    logic ok_hold = 1'b1;
    bank_in = '1; resp_rx_ch = 0; resp_tx_ch = 1; resp_plen = 1;
    exp_first = 8'hA6; exp_last = 8'hA6; seen = 1'b0; resp_mode = 1;
    nrec = 0; oe_n = 0; oe_bad = 0; res_ready = 1'b0;
    run_sweep(2, 1, 128'hA6);
    while (!res_valid && busy) @(negedge clk);
    held = res_data;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!res_valid || res_data != held || pin_oe != 4'b0001) ok_hold = 1'b0;
    end
    check(ok_hold, "R11", "record held while not ready", ok_hold, 1);
    res_ready = 1'b1;
    wait_idle();
    check(!busy, "R12", "sweep ends", busy, 0);
    for (int i = 0; i < nrec; i++) begin
      if (rec_tx[i] != 0 || rec_rx[i] != 1) wrong++;
      if (rec_baud[i] == 11) hit = i;
    end
    check(wrong == 0, "R10", "records only for the live pair", wrong, 0);
    check(hit >= 0, "R3", "record at rate index 11", hit, 0);
    if (hit >= 0) begin
      check(rec_cnt[hit] == 2, "R9", "bad frame dropped, count", rec_cnt[hit], 2);
      check(rec_data[hit][15:0] == 16'hC33C, "R7", "late byte kept after restart",
            rec_data[hit][15:0], 16'hC33C);
    end
    check(seen, "R2", "probe framed and decoded by responder", seen, 1);
    check(oe_n == 2 && oe_log[0] == 4'b0001 && oe_log[1] == 4'b0010, "R4",
          "transmit channel order", oe_n, 2);
    check(oe_bad == 0, "R5", "one enable while busy", oe_bad, 0);
    resp_mode = 0;
  endtask

  task automatic t_console_b;
    int hit = -1, wrong = 0;
    logic [127:0] expd;
    bank_in = '1; resp_rx_ch = 1; resp_tx_ch = 0; resp_plen = 2;
    exp_first = 8'h4B; exp_last = 8'h96; seen = 1'b0; resp_mode = 2;
    nrec = 0; oe_n = 0; oe_bad = 0;
    run_sweep(2, 2, 128'h964B);
    wait_idle();
    for (int i = 0; i < nrec; i++) begin
      if (rec_tx[i] != 1 || rec_rx[i] != 0) wrong++;
      if (rec_baud[i] == 11) hit = i;
    end
    for (int k = 0; k < 16; k++) expd[8*k +: 8] = 8'(8'h10 + k);
    check(wrong == 0, "R5", "no record on undriven pair", wrong, 0);
    check(seen, "R6", "both probe bytes sent in order", seen, 1);
    check(hit >= 0, "R3", "record at rate index 11", hit, 0);
    if (hit >= 0) begin
      check(rec_cnt[hit] == 16, "R8", "count capped", rec_cnt[hit], 16);
      check(rec_data[hit] == expd, "R8", "first sixteen bytes", rec_data[hit][31:0], expd[31:0]);
    end
    check(oe_bad == 0, "R5", "one enable while busy", oe_bad, 0);
    resp_mode = 0;
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_one_channel();
    t_console_a();
    t_console_b();
    summary();
    $finish;
  end
endmodule